// File: doc/BRIEF.md
# Stack ALU Execution Unit

This unit carries out the arithmetic and logic opcodes of an 8-bit-opcode, two-register stack processor. It keeps the top two data elements in registers (`tos`, `nos`) and spills deeper elements into a small on-chip stack memory. Alongside these it holds the carry, overflow, sign and zero status bits. A sequencer presents one opcode per cycle with a valid strobe. The unit executes it when it belongs to the arithmetic/logic class and ignores it otherwise.

Binary operations come in two forms. A consuming form pops an operand. A keeping form leaves both operands in place and pushes the result. The form is picked by a 2-bit stack-effect field, and the data movement between the registers and the stack memory is derived from that field alone. Stack faults (a push onto a full stack or a pop from an empty one) set a sticky error output. The pointer then saturates instead of wrapping.

Top module: `stk_alu_unit`

## Requirements
- R1: An opcode executes only when `valid_i` is high, bit 7 is 0 and bits 6:5 equal 01. Any other opcode, or `valid_i` low, leaves `tos_o`, `nos_o`, `depth_o` and `status_o` unchanged.
- R2: With bits 4:3 = 01 (consume), codes 0..6 in bits 2:0 compute add, add-with-carry, NOS-TOS, TOS-NOS, AND, OR and XOR of NOS and TOS. The result goes to TOS, NOS is refilled from the stack memory, and depth falls by one.
- R3: With bits 4:3 = 10 (keep), the same codes compute the same results. The old NOS is written to the stack memory, the old TOS moves to NOS, the result goes to TOS, and depth rises by one.
- R4: Code 2 computes NOS minus TOS and code 3 computes TOS minus NOS. For both, carry is 1 when no borrow occurs.
- R5: Codes 0..3 of the consume and keep rows update carry (unsigned carry-out) and overflow (signed overflow). Code 1 adds the current carry as carry-in. Codes 4..7 leave carry and overflow unchanged.
- R6: Code 7 in the consume row drops NOS and keeps TOS. Code 7 in the keep row copies NOS over the top, so the result is TOS=old NOS and NOS=old TOS.
- R7: With bits 4:3 = 11, code 0 inverts TOS, code 6 sets TOS to all ones if it was zero and to all zeros otherwise, and code 7 sets TOS to all ones if it was negative and to all zeros otherwise. NOS and depth do not change. Codes 1..5 of this row are no-ops.
- R8: With bits 4:3 = 00, code 7 exchanges TOS and NOS. Codes 0..6 of this row are no-ops.
- R9: `status_o` holds carry at bit 0, overflow at bit 1, sign at bit 5 and zero at bit 6, with all other bits 0. After every executed opcode, sign equals the MSB of the new TOS and zero flags a new TOS of 0.
- R10: The stack memory holds 2^PTR_W entries (32 by default), and `depth_o` reports 0..32. A push at depth 32 or a pop at depth 0 sets `stack_err_o`, which then stays high until reset. Depth stays saturated. A pop at depth 0 leaves NOS unchanged.
- R11: Reset clears TOS, NOS, depth, the status bits and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Opcode strobe |
| opcode_i | input | 8 | Opcode: bit 7 literal flag, 6:5 class, 4:3 stack effect, 2:0 code |
| tos_o | output | W | Top-of-stack register |
| nos_o | output | W | Next-of-stack register |
| depth_o | output | PTR_W+1 | Number of entries in the stack memory |
| status_o | output | 8 | Status: carry 0, overflow 1, sign 5, zero 6 |
| stack_err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The hardest state to reach is signed overflow. No opcode loads a constant, so the only way to get a large operand is through the block's own arithmetic. The stimulus first derives all ones with a zero test, then adds it to itself to get -2, and inverts that to get 1. From there it doubles the value with pairs of "keep OR with NOS=0" and "consume add" opcodes, which leave depth and NOS fixed, until the sum crosses the sign boundary and then wraps to zero. A full stack is reached in the same way, by repeating a keeping opcode until the pointer saturates.

// File: rtl/stk_alu_pkg.sv
package stk_alu_pkg;

  typedef enum logic [1:0] {
    EFF_NONE = 2'b00,
    EFF_POP  = 2'b01,
    EFF_PUSH = 2'b10,
    EFF_BOTH = 2'b11
  } eff_e;

  typedef enum logic [1:0] {
    NSRC_KEEP = 2'b00,
    NSRC_TOS  = 2'b01,
    NSRC_MEM  = 2'b10
  } nos_src_e;

  typedef struct packed {
    logic     exec;
    logic     push;
    logic     pop;
    logic     arith;
    nos_src_e nos_src;
  } ctl_t;

  localparam logic [1:0] CLASS_ALU = 2'b01;

  localparam int ST_W = 8;
  localparam int ST_C = 0;
  localparam int ST_V = 1;
  localparam int ST_N = 5;
  localparam int ST_Z = 6;

endpackage

// File: rtl/stk_alu_dec.sv
module stk_alu_dec
  import stk_alu_pkg::*;
(
  input  logic       valid_i,
  input  logic [7:0] op_i,
  output ctl_t       ctl_o
);

  logic [2:0] code;
  eff_e       eff;
  logic       is_alu;

  assign code   = op_i[2:0];
  assign eff    = eff_e'(op_i[4:3]);
  assign is_alu = valid_i && !op_i[7] && (op_i[6:5] == CLASS_ALU);

  always_comb begin
    ctl_o.exec    = 1'b0;
    ctl_o.push    = 1'b0;
    ctl_o.pop     = 1'b0;
    ctl_o.arith   = 1'b0;
    ctl_o.nos_src = NSRC_KEEP;
    if (is_alu) begin
      unique case (eff)
        EFF_POP: begin
          ctl_o.exec    = 1'b1;
          ctl_o.pop     = 1'b1;
          ctl_o.arith   = !code[2];
          ctl_o.nos_src = NSRC_MEM;
        end
        EFF_PUSH: begin
          ctl_o.exec    = 1'b1;
          ctl_o.push    = 1'b1;
          ctl_o.arith   = !code[2];
          ctl_o.nos_src = NSRC_TOS;
        end
        EFF_BOTH: begin
          ctl_o.exec = (code == 3'd0) || (code == 3'd6) || (code == 3'd7);
        end
        default: begin
          if (code == 3'd7) begin
            ctl_o.exec    = 1'b1;
            ctl_o.nos_src = NSRC_TOS;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/stk_alu_calc.sv
module stk_alu_calc
  import stk_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] tos_i,
  input  logic [W-1:0] nos_i,
  input  logic         cin_i,
  input  eff_e         eff_i,
  input  logic [2:0]   code_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,
  output logic         vout_o
);

  logic [W-1:0] opa, opb;
  logic         ci;
  logic [W:0]   sum;

  // operand steering: subtraction is a + ~b + 1
  always_comb begin
    opa = nos_i;
    opb = tos_i;
    ci  = 1'b0;
    unique case (code_i[1:0])
      2'd1: ci = cin_i;
      2'd2: begin opb = ~tos_i; ci = 1'b1; end
      2'd3: begin opa = tos_i; opb = ~nos_i; ci = 1'b1; end
      default: ;
    endcase
  end

  assign sum    = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, ci};
  assign cout_o = sum[W];
  assign vout_o = (opa[W-1] == opb[W-1]) && (sum[W-1] != opa[W-1]);

  always_comb begin
    res_o = tos_i;
    unique case (eff_i)
      EFF_POP, EFF_PUSH: begin
        unique case (code_i)
          3'd4:    res_o = nos_i & tos_i;
          3'd5:    res_o = nos_i | tos_i;
          3'd6:    res_o = nos_i ^ tos_i;
          3'd7:    res_o = (eff_i == EFF_POP) ? tos_i : nos_i;
          default: res_o = sum[W-1:0];
        endcase
      end
      EFF_BOTH: begin
        unique case (code_i)
          3'd0:    res_o = ~tos_i;
          3'd6:    res_o = {W{tos_i == '0}};
          3'd7:    res_o = {W{tos_i[W-1]}};
          default: res_o = tos_i;
        endcase
      end
      default: res_o = nos_i;
    endcase
  end

endmodule

// File: rtl/stk_alu_stack.sv
module stk_alu_stack #(
  parameter int W     = 32,
  parameter int PTR_W = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic           pop_i,
  input  logic [W-1:0]   wdata_i,
  output logic [W-1:0]   top_o,
  output logic [PTR_W:0] depth_o,
  output logic           fault_o
);

  localparam int CW    = PTR_W + 1;
  localparam int DEPTH = 1 << PTR_W;

  logic [W-1:0]    mem [DEPTH];
  logic [PTR_W:0]  depth_q;
  logic [PTR_W-1:0] wr_idx, rd_idx;
  logic            full, empty, do_push, do_pop;

  assign full    = (depth_q == DEPTH[PTR_W:0]);
  assign empty   = (depth_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty;
  assign wr_idx  = depth_q[PTR_W-1:0];
  assign rd_idx  = wr_idx - PTR_W'(1);
  assign fault_o = (push_i && full) || (pop_i && empty);
  assign top_o   = mem[rd_idx];
  assign depth_o = depth_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_idx] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      depth_q <= '0;
    else if (do_push) depth_q <= depth_q + CW'(1);
    else if (do_pop)  depth_q <= depth_q - CW'(1);
  end

endmodule

// File: rtl/stk_alu_unit.sv
module stk_alu_unit
  import stk_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int PTR_W = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [7:0]     opcode_i,
  output logic [W-1:0]   tos_o,
  output logic [W-1:0]   nos_o,
  output logic [PTR_W:0] depth_o,
  output logic [ST_W-1:0] status_o,
  output logic           stack_err_o
);

  ctl_t         ctl;
  logic [W-1:0] tos_q, nos_q, res, mem_top;
  logic         c_q, v_q, n_q, z_q, err_q;
  logic         cout, vout, fault;
  logic [PTR_W:0] depth;

  stk_alu_dec u_dec (
    .valid_i (valid_i),
    .op_i    (opcode_i),
    .ctl_o   (ctl)
  );

  stk_alu_calc #(.W(W)) u_calc (
    .tos_i  (tos_q),
    .nos_i  (nos_q),
    .cin_i  (c_q),
    .eff_i  (eff_e'(opcode_i[4:3])),
    .code_i (opcode_i[2:0]),
    .res_o  (res),
    .cout_o (cout),
    .vout_o (vout)
  );

  stk_alu_stack #(.W(W), .PTR_W(PTR_W)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (ctl.push),
    .pop_i   (ctl.pop),
    .wdata_i (nos_q),
    .top_o   (mem_top),
    .depth_o (depth),
    .fault_o (fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tos_q <= '0;
      nos_q <= '0;
      c_q   <= 1'b0;
      v_q   <= 1'b0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (ctl.exec) begin
        tos_q <= res;
        n_q   <= res[W-1];
        z_q   <= (res == '0);
        unique case (ctl.nos_src)
          NSRC_TOS: nos_q <= tos_q;
          NSRC_MEM: if (depth != '0) nos_q <= mem_top;
          default:  ;
        endcase
        if (ctl.arith) begin
          c_q <= cout;
          v_q <= vout;
        end
      end
      if (fault) err_q <= 1'b1;
    end
  end

  always_comb begin
    status_o       = '0;
    status_o[ST_C] = c_q;
    status_o[ST_V] = v_q;
    status_o[ST_N] = n_q;
    status_o[ST_Z] = z_q;
  end

  assign tos_o       = tos_q;
  assign nos_o       = nos_q;
  assign depth_o     = depth;
  assign stack_err_o = err_q;

endmodule

// File: rtl/stk_alu_chk.sv
module stk_alu_chk #(
  parameter int W     = 32,
  parameter int PTR_W = 5
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic [7:0]     opcode_i,
  input logic [W-1:0]   tos_o,
  input logic [W-1:0]   nos_o,
  input logic [PTR_W:0] depth_o,
  input logic [7:0]     status_o,
  input logic           stack_err_o
);

  localparam int CW    = PTR_W + 1;
  localparam int DEPTH = 1 << PTR_W;

  logic is_alu, row_pop, row_push, row_both;
  assign is_alu   = valid_i && (opcode_i[7:5] == 3'b001);
  assign row_pop  = is_alu && (opcode_i[4:3] == 2'b01);
  assign row_push = is_alu && (opcode_i[4:3] == 2'b10);
  assign row_both = is_alu && (opcode_i[4:3] == 2'b11);

  AST_FOREIGN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_alu |=> $stable(tos_o) && $stable(nos_o) && $stable(depth_o) && $stable(status_o)); // R1

  AST_POP_SHRINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_pop && depth_o != '0 |=> depth_o == $past(depth_o) - CW'(1)); // R2

  AST_PUSH_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_push && depth_o != DEPTH[PTR_W:0] |=> depth_o == $past(depth_o) + CW'(1) && nos_o == $past(tos_o)); // R3

  AST_LOGIC_KEEPS_CV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_pop || row_push) && opcode_i[2] |=> $stable(status_o[1:0])); // R5

  AST_UNARY_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_both |=> $stable(nos_o) && $stable(depth_o)); // R7

  AST_FLAG_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_both && opcode_i[2:1] == 2'b11 |=> (tos_o == '0 || tos_o == '1)); // R7

  AST_SWAP_XCHG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_alu && opcode_i[4:0] == 5'b00111 |=> tos_o == $past(nos_o) && nos_o == $past(tos_o)); // R8

  AST_SIGN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_pop || row_push |=> status_o[6] == (tos_o == '0) && status_o[5] == tos_o[W-1]); // R9

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_err_o |=> stack_err_o); // R10

  AST_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_pop && depth_o == '0 |=> stack_err_o && depth_o == '0 && $stable(nos_o)); // R10

  AST_DEPTH_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= DEPTH[PTR_W:0]); // R10

endmodule

bind stk_alu_unit stk_alu_chk #(.W(W), .PTR_W(PTR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .opcode_i    (opcode_i),
  .tos_o       (tos_o),
  .nos_o       (nos_o),
  .depth_o     (depth_o),
  .status_o    (status_o),
  .stack_err_o (stack_err_o)
);

// File: tb/stk_alu_unit_tb.sv
module stk_alu_unit_tb;

  localparam int W     = 8;
  localparam int PTR_W = 5;
  localparam int NV    = 48;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b1;
  logic           valid_i = 1'b0;
  logic [7:0]     opcode_i = 8'h00;
  logic [W-1:0]   tos_o, nos_o;
  logic [PTR_W:0] depth_o;
  logic [7:0]     status_o;
  logic           stack_err_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  stk_alu_unit #(.W(W), .PTR_W(PTR_W)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .opcode_i    (opcode_i),
    .tos_o       (tos_o),
    .nos_o       (nos_o),
    .depth_o     (depth_o),
    .status_o    (status_o),
    .stack_err_o (stack_err_o)
  );

  // {req, opcode, tos, nos, depth, status}; status: c=01 v=02 n=20 z=40
  localparam logic [41:0] VEC [NV] = '{
    {4'd7, 8'h3E, 8'hFF, 8'h00, 6'd0, 8'h20},  // R7 zero test true
    {4'd3, 8'h30, 8'hFF, 8'hFF, 6'd1, 8'h20},  // R3 keep add
    {4'd5, 8'h30, 8'hFE, 8'hFF, 6'd2, 8'h21},  // R5 carry out
    {4'd5, 8'h31, 8'hFE, 8'hFE, 6'd3, 8'h21},  // R5 add with carry-in
    {4'd7, 8'h38, 8'h01, 8'hFE, 6'd3, 8'h01},  // R7 invert
    {4'd4, 8'h32, 8'hFD, 8'h01, 6'd4, 8'h21},  // R4 keep NOS-TOS
    {4'd4, 8'h33, 8'hFC, 8'hFD, 6'd5, 8'h21},  // R4 keep TOS-NOS
    {4'd4, 8'h2A, 8'h01, 8'h01, 6'd4, 8'h01},  // R4 consume NOS-TOS
    {4'd9, 8'h2B, 8'h00, 8'hFE, 6'd3, 8'h41},  // R9 zero flag
    {4'd2, 8'h2A, 8'hFE, 8'hFF, 6'd2, 8'h21},  // R2 refill from memory
    {4'd4, 8'h2B, 8'hFF, 8'hFF, 6'd1, 8'h20},  // R4 borrow clears carry
    {4'd7, 8'h38, 8'h00, 8'hFF, 6'd1, 8'h40},  // R7
    {4'd3, 8'h36, 8'hFF, 8'h00, 6'd2, 8'h20},  // R3 keep xor
    {4'd2, 8'h2C, 8'h00, 8'hFF, 6'd1, 8'h40},  // R2 consume and
    {4'd3, 8'h35, 8'hFF, 8'h00, 6'd2, 8'h20},  // R3 keep or
    {4'd3, 8'h35, 8'hFF, 8'hFF, 6'd3, 8'h20},  // R3
    {4'd2, 8'h28, 8'hFE, 8'h00, 6'd2, 8'h21},  // R2 consume add
    {4'd7, 8'h38, 8'h01, 8'h00, 6'd2, 8'h01},  // R7
    {4'd5, 8'h35, 8'h01, 8'h01, 6'd3, 8'h01},  // R5 doubling pairs
    {4'd5, 8'h28, 8'h02, 8'h00, 6'd2, 8'h00},
    {4'd5, 8'h35, 8'h02, 8'h02, 6'd3, 8'h00},
    {4'd5, 8'h28, 8'h04, 8'h00, 6'd2, 8'h00},
    {4'd5, 8'h35, 8'h04, 8'h04, 6'd3, 8'h00},
    {4'd5, 8'h28, 8'h08, 8'h00, 6'd2, 8'h00},
    {4'd5, 8'h35, 8'h08, 8'h08, 6'd3, 8'h00},
    {4'd5, 8'h28, 8'h10, 8'h00, 6'd2, 8'h00},
    {4'd5, 8'h35, 8'h10, 8'h10, 6'd3, 8'h00},
    {4'd5, 8'h28, 8'h20, 8'h00, 6'd2, 8'h00},
    {4'd5, 8'h35, 8'h20, 8'h20, 6'd3, 8'h00},
    {4'd5, 8'h28, 8'h40, 8'h00, 6'd2, 8'h00},
    {4'd5, 8'h35, 8'h40, 8'h40, 6'd3, 8'h00},
    {4'd5, 8'h28, 8'h80, 8'h00, 6'd2, 8'h22},  // R5 signed overflow
    {4'd9, 8'h35, 8'h80, 8'h80, 6'd3, 8'h22},  // R9 sign flag
    {4'd5, 8'h28, 8'h00, 8'h00, 6'd2, 8'h43},  // R5 carry and overflow
    {4'd5, 8'h29, 8'h01, 8'hFF, 6'd1, 8'h00},  // R5 carry-in used
    {4'd6, 8'h37, 8'hFF, 8'h01, 6'd2, 8'h20},  // R6 over
    {4'd8, 8'h27, 8'h01, 8'hFF, 6'd2, 8'h00},  // R8 swap
    {4'd6, 8'h2F, 8'h01, 8'hFF, 6'd1, 8'h00},  // R6 nip
    {4'd2, 8'h2D, 8'hFF, 8'h00, 6'd0, 8'h20},  // R2 consume or
    {4'd7, 8'h3F, 8'hFF, 8'h00, 6'd0, 8'h20},  // R7 negative test true
    {4'd7, 8'h38, 8'h00, 8'h00, 6'd0, 8'h40},  // R7
    {4'd7, 8'h3F, 8'h00, 8'h00, 6'd0, 8'h40},  // R7 negative test false
    {4'd7, 8'h3E, 8'hFF, 8'h00, 6'd0, 8'h20},  // R7
    {4'd7, 8'h39, 8'hFF, 8'h00, 6'd0, 8'h20},  // R7 unused unary code
    {4'd8, 8'h20, 8'hFF, 8'h00, 6'd0, 8'h20},  // R8 unused code in row 00
    {4'd1, 8'h40, 8'hFF, 8'h00, 6'd0, 8'h20},  // R1 memory class
    {4'd1, 8'hA8, 8'hFF, 8'h00, 6'd0, 8'h20},  // R1 literal flag set
    {4'd1, 8'h08, 8'hFF, 8'h00, 6'd0, 8'h20}   // R1 branch class
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic run_op(input logic [7:0] op, input logic vld);
    valid_i  = vld;
    opcode_i = op;
    @(negedge clk);
    valid_i  = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2;
    do_reset();
    check("R11", "reset state", {7'd0, tos_o, nos_o, depth_o, status_o, stack_err_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][37:30], 1'b1);
      check($sformatf("R%0d", VEC[i][41:38]), $sformatf("row %0d", i),
            {2'b0, tos_o, nos_o, depth_o, status_o}, {2'b0, VEC[i][29:0]});
    end
    check("R10", "no fault during table", {31'd0, stack_err_o}, 32'd0);

    // R1: valid low blocks execution
    run_op(8'h30, 1'b0);
    check("R1", "valid low", {2'b0, tos_o, nos_o, depth_o, status_o}, {2'b0, 8'hFF, 8'h00, 6'd0, 8'h20});

    // R10: consume at depth 0
    run_op(8'h28, 1'b1);
    check("R10", "underflow state", {1'b0, tos_o, nos_o, depth_o, status_o, stack_err_o},
          {1'b0, 8'hFF, 8'h00, 6'd0, 8'h20, 1'b1});
    run_op(8'h3E, 1'b1);
    check("R10", "error sticky", {23'd0, tos_o, stack_err_o}, {23'd0, 8'h00, 1'b1});

    // R11: reset from a dirty state
    do_reset();
    check("R11", "reset clears error", {7'd0, tos_o, nos_o, depth_o, status_o, stack_err_o}, 32'd0);

    // R10: fill to capacity, then one push too many
    for (int k = 0; k < 32; k++) run_op(8'h35, 1'b1);
    check("R10", "full depth", {25'd0, depth_o, stack_err_o}, {25'd0, 6'd32, 1'b0});
    run_op(8'h35, 1'b1);
    check("R10", "overflow saturates", {25'd0, depth_o, stack_err_o}, {25'd0, 6'd32, 1'b1});
    run_op(8'h2F, 1'b1);
    check("R6", "nip after full", {1'b0, tos_o, nos_o, depth_o, status_o, stack_err_o},
          {1'b0, 8'h00, 8'h00, 6'd31, 8'h40, 1'b1});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule